// File: doc/BRIEF.md
# Compressing Core Test Wrapper

This block sits between one embedded core and the rest of the chip so that the core can be exercised through a narrow test bus rather than through full parallel access to all of its pins. A three-bit mode code, sampled on each rising clock edge, picks one of five operating states. In the functional state the wrapper is transparent. In the core test state, each word on the narrow test input bus is widened by an XOR expansion network into a full core input vector. A separate XOR compaction network folds the wide core response onto the narrow test output bus. One bus word goes in and one word comes out per test cycle, so compression narrows the bus without lengthening the test.

The remaining states support isolation and the checking of the wiring around the core. In the isolation state the core inputs are tied to a constant. In the input interconnect state the functional inputs are fed into the same compaction network and observed on the test output bus. In the output interconnect state the functional outputs are driven from the test input bus through the expansion network. Clock and reset pass straight through to the core in every state.

The states are FUNCTIONAL (code 0), CORE_TEST (code 1), ISOLATE (code 2), IN_INTERCONNECT (code 3) and OUT_INTERCONNECT (code 4). Reset enters ISOLATE. On every rising edge the state moves to the state named by the sampled code. Codes 5, 6 and 7 move it to ISOLATE. Any state can reach any other state in one edge.

Top module: `xorc_test_wrapper`

## Requirements
- R1: While reset is asserted and after its release, before the first rising edge, the state is ISOLATE. In that state core_in equals ISO_VAL and both func_out and tout are zero.
- R2: In FUNCTIONAL (code 0), core_in equals func_in, func_out equals core_out, and tout is zero.
- R3: In ISOLATE (code 2), core_in equals ISO_VAL whatever func_in holds, and func_out and tout are zero.
- R4: In CORE_TEST (code 1), core_in bit i equals the XOR of the tin bits c for which bit i*TI_W+c of DEC_MASK is 1. func_out is zero.
- R5: In CORE_TEST, tout bit j equals the XOR of the bits c of core_out for which bit j*ENC_W+c of ENC_MASK is 1. ENC_W is the larger of CI_W and CO_W, and core_out is zero-extended to ENC_W.
- R6: In IN_INTERCONNECT (code 3), tout is formed by the R5 rule applied to func_in zero-extended to ENC_W. core_in equals ISO_VAL and func_out is zero.
- R7: In OUT_INTERCONNECT (code 4), func_out bit k equals bit (k mod CI_W) of the R4 expansion of tin. core_in equals ISO_VAL and tout is zero.
- R8: Codes 5, 6 and 7 give exactly the ISOLATE behaviour of R3.
- R9: A new mode code takes effect only at the next rising clock edge. Between edges the outputs follow the previously sampled code.
- R10: core_clk equals clk and core_rst_n equals rst_n at all times, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wrapper clock, also forwarded to the core |
| rst_n | input | 1 | Active-low asynchronous reset, also forwarded to the core |
| mode_in | input | 3 | Mode code, sampled on the rising edge |
| func_in | input | CI_W | Functional inputs from the surrounding logic |
| func_out | output | CO_W | Functional outputs to the surrounding logic |
| tin | input | TI_W | Narrow test input bus |
| tout | output | TO_W | Narrow test output bus |
| core_clk | output | 1 | Clock to the core |
| core_rst_n | output | 1 | Reset to the core |
| core_in | output | CI_W | Core input vector |
| core_out | input | CO_W | Core response vector |

## Verification
The assertions assume that mode_in is stable around each rising edge. They also assume that the data inputs are settled whenever a clock edge samples the combinational outputs, so each output reflects the code captured one edge earlier. The bench changes mode_in, func_in and tin only on falling edges. It samples the outputs shortly after the next rising edge, once the state and the XOR networks have settled. Random codes cover all eight values, including the three unused ones. Directed steps cover all-zero and all-one buses and the instant just before a code is captured.

// File: rtl/xorc_wrap_pkg.sv
package xorc_wrap_pkg;

    typedef enum logic [2:0] {
        ST_FUNCTIONAL       = 3'd0,
        ST_CORE_TEST        = 3'd1,
        ST_ISOLATE          = 3'd2,
        ST_IN_INTERCONNECT  = 3'd3,
        ST_OUT_INTERCONNECT = 3'd4
    } wrap_state_e;

    localparam int MASK_MAX = 4096;

    // Deterministic default connection matrix: every row touches at least one column.
    function automatic logic [MASK_MAX-1:0] default_mask(input int rows, input int cols);
        logic [MASK_MAX-1:0] m;
        m = '0;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                if ((c == (r % cols)) || (c == ((r / cols + r + 1) % cols))) begin
                    m[r*cols + c] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wrap_mode_ctrl.sv
module wrap_mode_ctrl
    import xorc_wrap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  mode_in,
    output wrap_state_e state,
    output logic        sel_func,
    output logic        sel_core,
    output logic        sel_iso,
    output logic        sel_in_ic,
    output logic        sel_out_ic
);

    wrap_state_e state_nxt;

    always_comb begin
        unique case (mode_in)
            3'd0:    state_nxt = ST_FUNCTIONAL;
            3'd1:    state_nxt = ST_CORE_TEST;
            3'd2:    state_nxt = ST_ISOLATE;
            3'd3:    state_nxt = ST_IN_INTERCONNECT;
            3'd4:    state_nxt = ST_OUT_INTERCONNECT;
            default: state_nxt = ST_ISOLATE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ISOLATE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        sel_func   = 1'b0;
        sel_core   = 1'b0;
        sel_iso    = 1'b0;
        sel_in_ic  = 1'b0;
        sel_out_ic = 1'b0;
        unique case (state)
            ST_FUNCTIONAL:       sel_func   = 1'b1;
            ST_CORE_TEST:        sel_core   = 1'b1;
            ST_IN_INTERCONNECT:  sel_in_ic  = 1'b1;
            ST_OUT_INTERCONNECT: sel_out_ic = 1'b1;
            default:             sel_iso    = 1'b1;
        endcase
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_func, sel_core, sel_iso, sel_in_ic, sel_out_ic}) == 1); // R8

    AST_UNUSED_TO_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode_in) >= 3'd5)) |-> (state == ST_ISOLATE)); // R8

endmodule

// File: rtl/wrap_xor_expand.sv
module wrap_xor_expand #(
    parameter int                     IN_W  = 8,
    parameter int                     OUT_W = 32,
    parameter logic [OUT_W*IN_W-1:0] MASK  = '1
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    for (genvar i = 0; i < OUT_W; i++) begin : g_row
        assign dout[i] = ^(din & MASK[i*IN_W +: IN_W]);
    end

endmodule

// File: rtl/wrap_xor_compact.sv
module wrap_xor_compact #(
    parameter int                     IN_W  = 32,
    parameter int                     OUT_W = 6,
    parameter logic [OUT_W*IN_W-1:0] MASK  = '1
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    for (genvar j = 0; j < OUT_W; j++) begin : g_tree
        logic [IN_W-1:0] picked;
        assign picked  = din & MASK[j*IN_W +: IN_W];
        assign dout[j] = ^picked;
    end

endmodule

// File: rtl/xorc_test_wrapper.sv
module xorc_test_wrapper
    import xorc_wrap_pkg::*;
#(
    parameter int CI_W = 32,
    parameter int CO_W = 24,
    parameter int TI_W = 8,
    parameter int TO_W = 6,
    parameter logic [CI_W*TI_W-1:0] DEC_MASK = (CI_W*TI_W)'(default_mask(CI_W, TI_W)),
    parameter logic [TO_W*max_int(CI_W, CO_W)-1:0] ENC_MASK =
        (TO_W*max_int(CI_W, CO_W))'(default_mask(TO_W, max_int(CI_W, CO_W))),
    parameter logic [CI_W-1:0] ISO_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode_in,
    input  logic [CI_W-1:0] func_in,
    output logic [CO_W-1:0] func_out,
    input  logic [TI_W-1:0] tin,
    output logic [TO_W-1:0] tout,
    output logic            core_clk,
    output logic            core_rst_n,
    output logic [CI_W-1:0] core_in,
    input  logic [CO_W-1:0] core_out
);

    localparam int ENC_W = max_int(CI_W, CO_W);

    wrap_state_e     state;
    logic            sel_func, sel_core, sel_iso, sel_in_ic, sel_out_ic;
    logic [CI_W-1:0] dec_vec;
    logic [ENC_W-1:0] enc_src;
    logic [TO_W-1:0] enc_vec;
    logic [CO_W-1:0] ic_drive;

    assign core_clk   = clk;
    assign core_rst_n = rst_n;

    wrap_mode_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_in    (mode_in),
        .state      (state),
        .sel_func   (sel_func),
        .sel_core   (sel_core),
        .sel_iso    (sel_iso),
        .sel_in_ic  (sel_in_ic),
        .sel_out_ic (sel_out_ic)
    );

    wrap_xor_expand #(.IN_W(TI_W), .OUT_W(CI_W), .MASK(DEC_MASK)) u_expand (
        .din  (tin),
        .dout (dec_vec)
    );

    assign enc_src = sel_in_ic ? ENC_W'(func_in) : ENC_W'(core_out);

    wrap_xor_compact #(.IN_W(ENC_W), .OUT_W(TO_W), .MASK(ENC_MASK)) u_compact (
        .din  (enc_src),
        .dout (enc_vec)
    );

    for (genvar k = 0; k < CO_W; k++) begin : g_fan
        assign ic_drive[k] = dec_vec[k % CI_W];
    end

    always_comb begin
        core_in  = ISO_VAL;
        func_out = '0;
        tout     = '0;
        unique case (state)
            ST_FUNCTIONAL: begin
                core_in  = func_in;
                func_out = core_out;
            end
            ST_CORE_TEST: begin
                core_in = dec_vec;
                tout    = enc_vec;
            end
            ST_IN_INTERCONNECT: begin
                tout = enc_vec;
            end
            ST_OUT_INTERCONNECT: begin
                func_out = ic_drive;
            end
            default: begin
                core_in = ISO_VAL;
            end
        endcase
    end

    AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode_in) == 3'd0)) |-> (core_in == func_in && func_out == core_out && tout == '0)); // R2

    AST_ISO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode_in) == 3'd2 || $past(mode_in) >= 3'd5))
        |-> (core_in == ISO_VAL && func_out == '0 && tout == '0)); // R3

    AST_OUTIC_CORE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode_in) == 3'd4)) |-> (core_in == ISO_VAL && tout == '0)); // R7

    AST_EXPAND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_core && tin == '0) |-> (core_in == '0)); // R4

    AST_COMPACT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in_ic && func_in == '0) |-> (tout == '0)); // R6

endmodule

// File: tb/sim_xorc_test_wrapper.sv
module sim_xorc_test_wrapper;

    localparam int CI_W = 8;
    localparam int CO_W = 6;
    localparam int TI_W = 3;
    localparam int TO_W = 2;
    localparam int ENC_W = 8;
    localparam logic [CI_W*TI_W-1:0]  DMASK = 24'b011111101110011100010001;
    localparam logic [TO_W*ENC_W-1:0] EMASK = 16'b1100101110110101;
    localparam logic [CI_W-1:0]       ISOV  = 8'hA5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      mode_in = 3'd0;
    logic [CI_W-1:0] func_in = '0;
    logic [CO_W-1:0] func_out;
    logic [TI_W-1:0] tin = '0;
    logic [TO_W-1:0] tout;
    logic            core_clk, core_rst_n;
    logic [CI_W-1:0] core_in;
    logic [CO_W-1:0] core_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    // behavioural core model
    assign core_out = core_in[5:0] ^ {core_in[7:6], core_in[7:4]};

    xorc_test_wrapper #(
        .CI_W(CI_W), .CO_W(CO_W), .TI_W(TI_W), .TO_W(TO_W),
        .DEC_MASK(DMASK), .ENC_MASK(EMASK), .ISO_VAL(ISOV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .func_in(func_in),
        .func_out(func_out), .tin(tin), .tout(tout), .core_clk(core_clk),
        .core_rst_n(core_rst_n), .core_in(core_in), .core_out(core_out)
    );

    function automatic logic [CI_W-1:0] expand(input logic [TI_W-1:0] t);
        logic [CI_W-1:0] r;
        for (int i = 0; i < CI_W; i++) begin
            r[i] = 1'b0;
            for (int c = 0; c < TI_W; c++) r[i] = r[i] ^ (t[c] & DMASK[i*TI_W + c]);
        end
        return r;
    endfunction

    function automatic logic [TO_W-1:0] compact(input logic [ENC_W-1:0] s);
        logic [TO_W-1:0] r;
        for (int j = 0; j < TO_W; j++) begin
            r[j] = 1'b0;
            for (int c = 0; c < ENC_W; c++) r[j] = r[j] ^ (s[c] & EMASK[j*ENC_W + c]);
        end
        return r;
    endfunction

    function automatic logic [CO_W-1:0] core_model(input logic [CI_W-1:0] x);
        return x[5:0] ^ {x[7:6], x[7:4]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare all outputs against the model for mode m
    task automatic check_all(input string req, input logic [2:0] m);
        logic [CI_W-1:0] e_ci;
        logic [CO_W-1:0] e_fo;
        logic [TO_W-1:0] e_to;
        logic [CI_W-1:0] ex;
        ex   = expand(tin);
        e_ci = ISOV;
        e_fo = '0;
        e_to = '0;
        case (m)
            3'd0: begin e_ci = func_in; e_fo = core_model(func_in); end
            3'd1: begin e_ci = ex; e_to = compact(ENC_W'(core_model(ex))); end
            3'd3: e_to = compact(ENC_W'(func_in));
            3'd4: for (int k = 0; k < CO_W; k++) e_fo[k] = ex[k % CI_W];
            default: ;
        endcase
        check({req, " core_in"},  32'(core_in),  32'(e_ci));
        check({req, " func_out"}, 32'(func_out), 32'(e_fo));
        check({req, " tout"},     32'(tout),     32'(e_to));
    endtask

    task automatic step(input logic [2:0] m, input logic [CI_W-1:0] f, input logic [TI_W-1:0] t);
        @(negedge clk);
        mode_in = m;
        func_in = f;
        tin     = t;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        mode_in = 3'd0;
        func_in = 8'h3C;
        #20;
        // R1: held in reset, isolation even though code 0 is presented
        check_all("R1 in reset", 3'd2);
        check("R10 reset pass", 32'(core_rst_n), 32'(rst_n));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1 after release", 3'd2);
        check("R10 reset pass high", 32'(core_rst_n), 32'(rst_n));
        check("R10 clock pass low", 32'(core_clk), 32'(clk));
        @(posedge clk);
        #1;
        check("R10 clock pass high", 32'(core_clk), 32'(clk));

        // R2 functional
        step(3'd0, 8'h5A, 3'd7);
        check_all("R2 functional a", 3'd0);
        step(3'd0, 8'hFF, 3'd0);
        check_all("R2 functional b", 3'd0);

        // R3 isolation ignores func_in
        step(3'd2, 8'h00, 3'd5);
        check_all("R3 isolate a", 3'd2);
        step(3'd2, 8'hFF, 3'd2);
        check_all("R3 isolate b", 3'd2);

        // R4 R5 core test, every test word
        for (int t = 0; t < 8; t++) begin
            step(3'd1, 8'h96, 3'(t));
            check_all("R4 R5 core test", 3'd1);
        end

        // R6 input interconnect
        step(3'd3, 8'h01, 3'd3);
        check_all("R6 input ic a", 3'd3);
        step(3'd3, 8'hC3, 3'd6);
        check_all("R6 input ic b", 3'd3);

        // R7 output interconnect
        step(3'd4, 8'h77, 3'd1);
        check_all("R7 output ic a", 3'd4);
        step(3'd4, 8'h10, 3'd7);
        check_all("R7 output ic b", 3'd4);

        // R8 unused codes
        for (int m = 5; m < 8; m++) begin
            step(3'(m), 8'hE7, 3'd4);
            check_all("R8 unused code", 3'd2);
        end

        // R9 new code waits for the edge
        step(3'd0, 8'h42, 3'd3);
        @(negedge clk);
        mode_in = 3'd2;
        #1;
        check_all("R9 before edge", 3'd0);
        @(posedge clk);
        #2;
        check_all("R9 after edge", 3'd2);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] m;
            m = 3'($urandom_range(0, 7));
            step(m, 8'($urandom), 3'($urandom));
            check_all("R2-R8 random", (m >= 3'd5) ? 3'd2 : m);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule